// File: doc/BRIEF.md
# Serial Port FIFO Threshold Controller

This block holds the transmit and receive sample queues of a synchronous serial port and turns their occupancy into service requests that pace an interrupt handler or a DMA engine. The bus side pushes transmit samples and pops received samples through one data path. It sees each queue's occupancy and its full and empty flags. It also programs two threshold fields and a port-enable bit. The serial side pops the next sample to shift out in each transmit slot and pushes each sample it has shifted in.

The port has no flow control. A received sample that finds its queue full is dropped and recorded as an overrun. A transmit slot that finds its queue empty sends the previous sample again and is recorded as an underrun. Both records stay set until software writes a one to clear them. A bus read from an empty receive queue returns the last value read and moves nothing. The threshold fields are stored one below the level they stand for, so a field of zero means "one sample".

The bus master should size its bursts from these requests: a receive burst no larger than the receive level that raised the request, and a transmit burst no larger than the free space left at the transmit level. In full-duplex use the serial side pushes one received sample for every transmit slot it pops.

Top module: `ssp_fifo_ctrl`

## Requirements
- R1: After reset, both occupancy counts read 0, both empty flags are 1, both full flags are 0, both error flags are 0, and with the port disabled both requests are 0.
- R2: With the port enabled, each bus write adds one sample to the transmit queue, and serial pops return the samples in write order. The count reaches FIFO_DEPTH (16) with the full flag set, and a bus write while full is discarded.
- R3: Serial pushes fill the receive queue and bus reads return the samples in arrival order. A bus read while the receive queue is empty returns the value of the previous successful read and leaves the receive count unchanged.
- R4: The transmit request is 1 exactly when the port is enabled and the transmit count is less than or equal to the transmit threshold field plus one. The field is log2(FIFO_DEPTH) = 4 bits wide.
- R5: The receive request is 1 exactly when the port is enabled and the receive count is greater than or equal to the receive threshold field plus one. A field of 15 therefore requests only when the queue holds 16.
- R6: A serial push while the receive queue is full sets the overrun flag on the next cycle. The sample is dropped, and the count and the stored samples are unchanged.
- R7: A serial pop while the transmit queue is empty sets the underrun flag on the next cycle. The transmit data output presents the most recently popped sample again.
- R8: Both error flags are sticky. A one on the matching clear input clears a flag on the next cycle, and a new error in the same cycle as a clear leaves the flag set.
- R9: With the enable bit at 0, both requests are 0 at once, both counts read 0 after one clock, and pushes, pops and error events have no effect on the counts or the error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Port enable; 0 flushes both queues |
| tx_thr | input | THR_W | Transmit threshold field (level minus one) |
| rx_thr | input | THR_W | Receive threshold field (level minus one) |
| bus_wr | input | 1 | Bus push into transmit queue |
| bus_wdata | input | SAMPLE_W | Bus write sample |
| bus_rd | input | 1 | Bus pop from receive queue |
| bus_rdata | output | SAMPLE_W | Receive head, or last read value when empty |
| clr_ovr | input | 1 | Write-one clear of overrun flag |
| clr_udr | input | 1 | Write-one clear of underrun flag |
| tx_level | output | CNT_W | Transmit queue occupancy |
| rx_level | output | CNT_W | Receive queue occupancy |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| ovr_flag | output | 1 | Sticky receive overrun |
| udr_flag | output | 1 | Sticky transmit underrun |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| ser_tx_pop | input | 1 | Serial transmit slot consumes a sample |
| ser_tx_data | output | SAMPLE_W | Sample for the current transmit slot |
| ser_rx_push | input | 1 | Serial side delivers a received sample |
| ser_rx_data | input | SAMPLE_W | Received sample |

## Verification
The hardest case to reach is an error that lands on a queue edge together with another event: an overrun that still has to drop its sample, an underrun in the same cycle as its clear, or an empty read right after a drain. The stimulus first fills each queue to exactly 16 with a fixed threshold of 15. This checks the request boundary on the last push, and the next push then overflows. Each queue is then drained one sample at a time against a bench-side model queue, and the extra read or slot that follows finds it empty. A short table of mixed simultaneous pushes and pops with changing thresholds covers the request comparisons at levels one either side of each threshold.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  // Transmit side wants service while occupancy is at or below field + 1.
  function automatic logic tx_low(input logic [31:0] level, input logic [31:0] field);
    return level <= (field + 32'd1);
  endfunction

  // Receive side wants service while occupancy is at or above field + 1.
  function automatic logic rx_high(input logic [31:0] level, input logic [31:0] field);
    return level >= (field + 32'd1);
  endfunction

endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= wptr + AW'(1);
      if (pop_ok)  rptr <= rptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/sfc_sticky.sv
module sfc_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  // A new event outranks a clear arriving in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

endmodule

// File: rtl/sfc_thr_req.sv
module sfc_thr_req #(
  parameter int THR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             en,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [THR_W-1:0] tx_thr,
  input  logic [THR_W-1:0] rx_thr,
  output logic             tx_req,
  output logic             rx_req
);
  import sfc_pkg::*;

  assign tx_req = en && tx_low(32'(tx_level), 32'(tx_thr));
  assign rx_req = en && rx_high(32'(rx_level), 32'(rx_thr));

endmodule

// File: rtl/ssp_fifo_ctrl.sv
module ssp_fifo_ctrl #(
  parameter int SAMPLE_W   = 32,
  parameter int FIFO_DEPTH = 16,
  localparam int THR_W     = $clog2(FIFO_DEPTH),
  localparam int CNT_W     = THR_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                port_en,
  input  logic [THR_W-1:0]    tx_thr,
  input  logic [THR_W-1:0]    rx_thr,
  input  logic                bus_wr,
  input  logic [SAMPLE_W-1:0] bus_wdata,
  input  logic                bus_rd,
  output logic [SAMPLE_W-1:0] bus_rdata,
  input  logic                clr_ovr,
  input  logic                clr_udr,
  output logic [CNT_W-1:0]    tx_level,
  output logic [CNT_W-1:0]    rx_level,
  output logic                tx_full,
  output logic                tx_empty,
  output logic                rx_full,
  output logic                rx_empty,
  output logic                ovr_flag,
  output logic                udr_flag,
  output logic                tx_req,
  output logic                rx_req,
  input  logic                ser_tx_pop,
  output logic [SAMPLE_W-1:0] ser_tx_data,
  input  logic                ser_rx_push,
  input  logic [SAMPLE_W-1:0] ser_rx_data
);

  // Named internal events, visible to the bound checker.
  logic                flush;
  logic                tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic                ovr_event, udr_event;
  logic [SAMPLE_W-1:0] tx_head, rx_head;
  logic [SAMPLE_W-1:0] last_rd, last_tx;

  assign flush     = !port_en;
  assign ovr_event = port_en && ser_rx_push && rx_full;
  assign udr_event = port_en && ser_tx_pop && tx_empty;

  sfc_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(bus_wr), .din(bus_wdata), .pop(ser_tx_pop),
    .head(tx_head), .level(tx_level), .full(tx_full), .empty(tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  sfc_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(ser_rx_push), .din(ser_rx_data), .pop(bus_rd),
    .head(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  // Last sample delivered on each side, replayed when its queue runs dry.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_rd <= '0;
      last_tx <= '0;
    end else begin
      if (rx_pop_ok) last_rd <= rx_head;
      if (tx_pop_ok) last_tx <= tx_head;
    end
  end

  assign bus_rdata   = rx_empty ? last_rd : rx_head;
  assign ser_tx_data = tx_empty ? last_tx : tx_head;

  sfc_sticky u_ovr (
    .clk(clk), .rst_n(rst_n), .set(ovr_event), .clr(clr_ovr), .flag(ovr_flag)
  );

  sfc_sticky u_udr (
    .clk(clk), .rst_n(rst_n), .set(udr_event), .clr(clr_udr), .flag(udr_flag)
  );

  sfc_thr_req #(.THR_W(THR_W), .CNT_W(CNT_W)) u_req (
    .en(port_en), .tx_level(tx_level), .rx_level(rx_level),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .tx_req(tx_req), .rx_req(rx_req)
  );

endmodule

// File: rtl/sfc_chk.sv
module sfc_chk #(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             port_en,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             ser_tx_pop,
  input logic             ser_rx_push,
  input logic             clr_ovr,
  input logic [CNT_W-1:0] tx_level,
  input logic [CNT_W-1:0] rx_level,
  input logic             tx_full,
  input logic             rx_full,
  input logic             rx_empty,
  input logic             ovr_flag,
  input logic             udr_flag,
  input logic             tx_req,
  input logic             rx_req,
  input logic             ovr_event,
  input logic             udr_event
);

  AST_TX_PUSH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && bus_wr && !tx_full && !ser_tx_pop |=> tx_level == $past(tx_level) + CNT_W'(1)); // R2

  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && bus_rd && rx_empty && !ser_rx_push |=> rx_level == '0); // R3

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_event |=> ovr_flag); // R6

  AST_OVR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && ser_rx_push && rx_full && !bus_rd |=> rx_level == CNT_W'(FIFO_DEPTH)); // R6

  AST_UDR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    udr_event |=> udr_flag); // R7

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag && !clr_ovr |=> ovr_flag); // R8

  AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> tx_level == '0 && rx_level == '0); // R9

  AST_DISABLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !tx_req && !rx_req); // R9

  AST_DISABLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en && !udr_flag |=> !udr_flag); // R9

endmodule

bind ssp_fifo_ctrl sfc_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .ser_tx_pop(ser_tx_pop), .ser_rx_push(ser_rx_push), .clr_ovr(clr_ovr),
  .tx_level(tx_level), .rx_level(rx_level), .tx_full(tx_full), .rx_full(rx_full),
  .rx_empty(rx_empty), .ovr_flag(ovr_flag), .udr_flag(udr_flag),
  .tx_req(tx_req), .rx_req(rx_req), .ovr_event(ovr_event), .udr_event(udr_event)
);

// File: tb/ssp_fifo_ctrl_tb.sv
`timescale 1ns/1ps
module ssp_fifo_ctrl_tb;

  localparam int W = 32;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 1'b0;
  logic [3:0] tx_thr = '0, rx_thr = '0;
  logic bus_wr = 0, bus_rd = 0, clr_ovr = 0, clr_udr = 0;
  logic ser_tx_pop = 0, ser_rx_push = 0;
  logic [W-1:0] bus_wdata = '0, ser_rx_data = '0;
  logic [W-1:0] bus_rdata, ser_tx_data;
  logic [4:0] tx_level, rx_level;
  logic tx_full, tx_empty, rx_full, rx_empty, ovr_flag, udr_flag, tx_req, rx_req;

  int n_run = 0;
  int n_fail = 0;
  logic [W-1:0] txq[$];
  logic [W-1:0] rxq[$];
  logic [W-1:0] exp_last_rd = '0;

  always #10 clk = ~clk;

  ssp_fifo_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .clr_ovr(clr_ovr), .clr_udr(clr_udr), .tx_level(tx_level), .rx_level(rx_level),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
    .ovr_flag(ovr_flag), .udr_flag(udr_flag), .tx_req(tx_req), .rx_req(rx_req),
    .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
    .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data)
  );

  typedef struct packed {
    logic       wr, rd, spop, spush;
    logic [3:0] tthr, rthr;
    logic [4:0] etl, erl;
    logic       etreq, erreq;
  } vec_t;

  // wr rd spop spush tthr rthr | tx_level rx_level tx_req rx_req
  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  4'd0,  5'd1, 5'd0, 1'b1, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'd0,  4'd0,  5'd2, 5'd1, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'd2,  4'd2,  5'd3, 5'd2, 1'b1, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'd1,  4'd2,  5'd4, 5'd3, 1'b0, 1'b1},
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'd3,  4'd2,  5'd3, 5'd2, 1'b1, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd1,  4'd1,  5'd3, 5'd2, 1'b0, 1'b1},
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'd15, 4'd15, 5'd2, 5'd1, 1'b1, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'd0,  4'd0,  5'd1, 5'd0, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; ser_tx_pop = 0; ser_rx_push = 0; clr_ovr = 0; clr_udr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 tx_level", W'(tx_level), 0);
    check("R1 rx_level", W'(rx_level), 0);
    check("R1 empties", W'({tx_empty, rx_empty}), 3);
    check("R1 fulls", W'({tx_full, rx_full}), 0);
    check("R1 errors", W'({ovr_flag, udr_flag}), 0);
    check("R1 requests", W'({tx_req, rx_req}), 0);

    port_en = 1'b1;
    step();

    // Table walk: R2 R3 R4 R5 levels and thresholds
    for (int i = 0; i < 8; i++) begin
      bus_wr = VEC[i].wr; bus_rd = VEC[i].rd;
      ser_tx_pop = VEC[i].spop; ser_rx_push = VEC[i].spush;
      tx_thr = VEC[i].tthr; rx_thr = VEC[i].rthr;
      bus_wdata = 32'hA0 + i; ser_rx_data = 32'h50 + i;
      #1;
      if (VEC[i].spop) check("R2 tx order", ser_tx_data, txq.pop_front());
      if (VEC[i].rd) begin
        exp_last_rd = rxq.pop_front();
        check("R3 rx order", bus_rdata, exp_last_rd);
      end
      if (VEC[i].wr) txq.push_back(bus_wdata);
      if (VEC[i].spush) rxq.push_back(ser_rx_data);
      step();
      check("R2 tx_level vec", W'(tx_level), W'(VEC[i].etl));
      check("R3 rx_level vec", W'(rx_level), W'(VEC[i].erl));
      check("R4 tx_req vec", W'(tx_req), W'(VEC[i].etreq));
      check("R5 rx_req vec", W'(rx_req), W'(VEC[i].erreq));
    end
    idle();

    // R3 empty read repeats the last value and moves nothing
    bus_rd = 1; #1;
    check("R3 empty read data", bus_rdata, exp_last_rd);
    step(); idle();
    check("R3 empty read level", W'(rx_level), 0);
    check("R3 empty read data after", bus_rdata, exp_last_rd);

    // R7 underrun: drain last tx sample, then pop an empty queue
    ser_tx_pop = 1; #1;
    check("R2 last tx", ser_tx_data, txq[0]);
    step();
    check("R7 no udr yet", W'(udr_flag), 0);
    #1;
    check("R7 repeat data", ser_tx_data, txq[0]);
    step(); idle();
    check("R7 udr set", W'(udr_flag), 1);
    void'(txq.pop_front());

    // R8 sticky, clear, and set-over-clear
    step();
    check("R8 udr sticky", W'(udr_flag), 1);
    ser_tx_pop = 1; clr_udr = 1;
    step(); idle();
    check("R8 set beats clear", W'(udr_flag), 1);
    clr_udr = 1;
    step(); idle();
    check("R8 udr cleared", W'(udr_flag), 0);

    // R2 fill to full, extra write dropped; R4 boundary
    tx_thr = 4'd15;
    for (int k = 0; k < D + 1; k++) begin
      bus_wr = 1; bus_wdata = 32'h100 + k;
      step();
    end
    idle();
    check("R2 full level", W'(tx_level), D);
    check("R2 full flags", W'({tx_full, tx_empty}), 2);
    check("R4 req at thr+1", W'(tx_req), 1);
    tx_thr = 4'd14; #1;
    check("R4 req above thr+1", W'(tx_req), 0);
    for (int k = 0; k < D; k++) begin
      ser_tx_pop = 1; #1;
      check("R2 full order", ser_tx_data, 32'h100 + k);
      step();
    end
    idle();
    check("R2 drained", W'({tx_level, tx_empty}), 1);
    check("R7 no udr on drain", W'(udr_flag), 0);

    // R5 boundary and R6 overrun
    rx_thr = 4'd15;
    for (int k = 0; k < D; k++) begin
      ser_rx_push = 1; ser_rx_data = 32'h200 + k;
      step();
      if (k == D - 2) check("R5 req below full", W'(rx_req), 0);
    end
    check("R5 req at full", W'(rx_req), 1);
    check("R6 no ovr yet", W'(ovr_flag), 0);
    ser_rx_data = 32'h2FF;
    step(); idle();
    check("R6 ovr set", W'(ovr_flag), 1);
    check("R6 level held", W'({rx_level, rx_full}), {D, 1'b1});
    for (int k = 0; k < D; k++) begin
      bus_rd = 1; #1;
      check("R6 data kept", bus_rdata, 32'h200 + k);
      step();
    end
    idle();
    check("R6 dropped sample absent", bus_rdata, 32'h200 + D - 1);
    check("R8 ovr sticky", W'(ovr_flag), 1);
    clr_ovr = 1;
    step(); idle();
    check("R8 ovr cleared", W'(ovr_flag), 0);

    // R9 disable flushes and ignores activity
    tx_thr = 4'd0; rx_thr = 4'd0;
    bus_wr = 1; ser_rx_push = 1;
    repeat (3) step();
    idle();
    check("R9 pre-disable", W'({tx_level, rx_level}), {5'd3, 5'd3});
    port_en = 0; #1;
    check("R9 req drop", W'({tx_req, rx_req}), 0);
    step();
    check("R9 flushed", W'({tx_level, rx_level}), 0);
    bus_wr = 1; ser_rx_push = 1; ser_tx_pop = 1; bus_rd = 1;
    step(); step(); idle();
    check("R9 ignored level", W'({tx_level, rx_level}), 0);
    check("R9 ignored errors", W'({ovr_flag, udr_flag}), 0);
    check("R9 req off", W'({tx_req, rx_req}), 0);
    port_en = 1; #1;
    check("R4 req after enable", W'(tx_req), 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule